// File: doc/BRIEF.md
# UART Interrupt Identification Prioritizer

This block gathers the interrupt conditions of one UART channel and reduces them to one status byte that the host reads to find out why the channel is asking for service. There are seven sources. Four of them are classic: receive line error, receive timeout, receive data available and modem status change, plus a transmitter-ready event. Two are enhanced: a flow-control or special-character match, and a CTS/RTS de-assertion. Each source is masked by its own enable bit. The two enhanced sources are also masked by a global enhanced-mode bit. Only the most urgent pending source is encoded. The status byte also reports whether the FIFOs are enabled.

The receive line error, receive timeout, receive data available and modem change inputs are levels. The logic that raises them also clears them. Transmitter-ready, flow-control match, special-character match and CTS/RTS de-assertion arrive as one-cycle pulses, and the block latches them. A latched event is dropped when the host reads the status byte while that event is the one reported. A special-character match is also dropped when the next received character is signalled. The status byte is frozen for the whole length of a read strobe. An interrupt request line mirrors the pending state.

Top module: `uart_irq_ident`

## Requirements
- R1: While `rst_n` is low at a clock edge, `isr_q` becomes 0x01 and `irq` becomes 0.
- R2: With one enabled source pending, `isr_q[5:0]` holds its code: line error 0x06, receive timeout 0x0C, data available 0x04, transmitter ready 0x02, modem change 0x00, match 0x10, CTS/RTS de-assertion 0x20. With nothing pending it holds 0x01.
- R3: With several enabled sources pending, the code reported is that of the most urgent one. The order from most to least urgent is: line error, receive timeout, data available, transmitter ready, modem change, match, CTS/RTS.
- R4: `isr_q[0]` is 0 exactly when an interrupt is pending, and `irq` always equals the inverse of `isr_q[0]`.
- R5: `isr_q[7:6]` reads 2'b11 when `fifo_en` is 1 and 2'b00 when it is 0, whatever interrupts are pending.
- R6: A source whose enable is 0 is never reported. `ie_rx` gates both receive timeout and data available.
- R7: The match level (code 0x10) is only reported when both `enh_en` and `ie_match` are 1.
- R8: The CTS/RTS level (code 0x20) is only reported when both `enh_en` and `ie_flow` are 1.
- R9: The transmitter-ready, flow-control-match and CTS/RTS events stay latched until the host reads the status byte while that event's code is the one reported. A read that reports another code leaves them latched.
- R10: A latched special-character match is dropped by a `rx_char` pulse as well as by a read.
- R11: `isr_q` keeps its value over every cycle of a read strobe. Only the first cycle of the strobe clears anything. An event that arrives during the strobe survives it.
- R12: Less urgent sources remain latched behind a more urgent one and are reported once the more urgent one goes away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lsr_err | input | 1 | Receive line error level |
| rx_tout | input | 1 | Receive timeout level |
| rx_avail | input | 1 | Receive data available level |
| tx_ready | input | 1 | Transmitter-ready event pulse |
| modem_chg | input | 1 | Modem status change level |
| xoff_hit | input | 1 | Flow-control character match pulse |
| spchar_hit | input | 1 | Special character match pulse |
| rx_char | input | 1 | Pulse marking a newly received character |
| flow_deassert | input | 1 | CTS or RTS de-assertion pulse |
| ie_line | input | 1 | Enable for line error |
| ie_rx | input | 1 | Enable for receive timeout and data available |
| ie_tx | input | 1 | Enable for transmitter ready |
| ie_modem | input | 1 | Enable for modem change |
| ie_match | input | 1 | Enable for character match |
| ie_flow | input | 1 | Enable for CTS/RTS de-assertion |
| enh_en | input | 1 | Enhanced mode enable |
| fifo_en | input | 1 | FIFOs enabled status |
| isr_rd | input | 1 | Host read strobe of the status byte |
| isr_q | output | 8 | Status byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The checker watches several properties on every cycle. `irq` must track the inverse of the pending bit, and the reported code must always be one of the eight legal values. The FIFO bits must follow `fifo_en` outside reads, and no enhanced code may appear while enhanced mode is off. The status byte must stay unchanged across each read strobe, and reset must leave the idle code. The bench covers the rest: priority across every combination of the seven sources, masking across every combination of the enables, and the read-to-clear sequence in which each latched event is revealed in turn. It also runs cases where the read sampling point matters: clearing by character arrival, and sources that show up in the middle of a strobe.

// File: rtl/uart_irq_pkg.sv
// Package: shared widths, source indices and status codes of the
// interrupt identification prioritizer. Index 0 is the most urgent source.
package uart_irq_pkg;

    localparam int ISR_W     = 8;
    localparam int CODE_W    = 6;
    localparam int FIFO_W    = ISR_W - CODE_W;
    localparam int NUM_SRC   = 7;

    // priority positions, 0 = most urgent
    localparam int P_LINE  = 0;
    localparam int P_TOUT  = 1;
    localparam int P_RXRDY = 2;
    localparam int P_TXRDY = 3;
    localparam int P_MODEM = 4;
    localparam int P_MATCH = 5;
    localparam int P_FLOW  = 6;

    // latched event slots
    localparam int NUM_EVT = 4;
    localparam int E_TX    = 0;
    localparam int E_XOFF  = 1;
    localparam int E_SPCH  = 2;
    localparam int E_FLOW  = 3;

    typedef enum logic [CODE_W-1:0] {
        CODE_LINE  = 6'h06,
        CODE_TOUT  = 6'h0C,
        CODE_RXRDY = 6'h04,
        CODE_TXRDY = 6'h02,
        CODE_MODEM = 6'h00,
        CODE_MATCH = 6'h10,
        CODE_FLOW  = 6'h20,
        CODE_NONE  = 6'h01
    } isr_code_e;

    // code for a priority position
    function automatic logic [CODE_W-1:0] code_of(input int idx);
        case (idx)
            P_LINE:  code_of = CODE_LINE;
            P_TOUT:  code_of = CODE_TOUT;
            P_RXRDY: code_of = CODE_RXRDY;
            P_TXRDY: code_of = CODE_TXRDY;
            P_MODEM: code_of = CODE_MODEM;
            P_MATCH: code_of = CODE_MATCH;
            P_FLOW:  code_of = CODE_FLOW;
            default: code_of = CODE_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irq_event_latch.sv
// Module: irq_event_latch
// A bank of sticky bits, one for each pulsed interrupt event.
// Assumes set and clear are single-cycle, synchronous strobes.
// When set and clear meet on the same bit, set wins, so no event is lost.
module irq_event_latch #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] hold_o
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        // hold one event until it is explicitly cleared
        always_ff @(posedge clk) begin
            if (!rst_n)
                hold_o[g] <= 1'b0;
            else if (set_i[g])
                hold_o[g] <= 1'b1;
            else if (clr_i[g])
                hold_o[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_prio_encoder.sv
// Module: irq_prio_encoder
// Purely combinational. It picks the most urgent pending source and
// returns its status code. Inputs must already be masked by their enables.
module irq_prio_encoder
    import uart_irq_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N-1:0]      pend_i,
    output logic [CODE_W-1:0] code_o
);

    // walk from least to most urgent so the most urgent source wins
    always_comb begin
        code_o = CODE_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i])
                code_o = code_of(i);
        end
    end

endmodule

// File: rtl/irq_read_ctrl.sv
// Module: irq_read_ctrl
// Registers the status byte and the request line. Holds both while the
// read strobe is high and flags the first cycle of each strobe, which is
// the only cycle where reading may clear a source.
module irq_read_ctrl
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              isr_rd,
    input  logic              fifo_en,
    input  logic [CODE_W-1:0] code_i,
    output logic [ISR_W-1:0]  isr_q,
    output logic              irq,
    output logic              rd_first
);

    logic rd_prev;

    // first cycle of a read strobe
    assign rd_first = isr_rd & ~rd_prev;

    // track the strobe so it is recognised only once
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_prev <= 1'b0;
        else
            rd_prev <= isr_rd;
    end

    // capture status outside reads, freeze it during a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= {{FIFO_W{1'b0}}, CODE_NONE};
            irq   <= 1'b0;
        end else if (!isr_rd) begin
            isr_q <= {{FIFO_W{fifo_en}}, code_i};
            irq   <= ~code_i[0];
        end
    end

endmodule

// File: rtl/uart_irq_ident.sv
// Module: uart_irq_ident (top)
// Merges the interrupt sources of one UART channel into a status byte and
// a request line. Level sources come straight from their owners. Pulsed
// events are latched here and cleared by a read that reports them; the
// special-character match also clears on the next received character.
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lsr_err,
    input  logic             rx_tout,
    input  logic             rx_avail,
    input  logic             tx_ready,
    input  logic             modem_chg,
    input  logic             xoff_hit,
    input  logic             spchar_hit,
    input  logic             rx_char,
    input  logic             flow_deassert,
    input  logic             ie_line,
    input  logic             ie_rx,
    input  logic             ie_tx,
    input  logic             ie_modem,
    input  logic             ie_match,
    input  logic             ie_flow,
    input  logic             enh_en,
    input  logic             fifo_en,
    input  logic             isr_rd,
    output logic [ISR_W-1:0] isr_q,
    output logic             irq
);

    logic [NUM_EVT-1:0] evt_set, evt_clr, evt_q;
    logic [NUM_SRC-1:0] pend;
    logic [CODE_W-1:0]  code;
    logic               rd_first;
    logic               rd_hits_tx, rd_hits_match, rd_hits_flow;

    // event pulses into the latch bank
    always_comb begin
        evt_set         = '0;
        evt_set[E_TX]   = tx_ready;
        evt_set[E_XOFF] = xoff_hit;
        evt_set[E_SPCH] = spchar_hit;
        evt_set[E_FLOW] = flow_deassert;
    end

    // a read clears only the event its sampled code names
    assign rd_hits_tx    = rd_first && (isr_q[CODE_W-1:0] == CODE_TXRDY);
    assign rd_hits_match = rd_first && (isr_q[CODE_W-1:0] == CODE_MATCH);
    assign rd_hits_flow  = rd_first && (isr_q[CODE_W-1:0] == CODE_FLOW);

    // clear conditions per latched event
    always_comb begin
        evt_clr         = '0;
        evt_clr[E_TX]   = rd_hits_tx;
        evt_clr[E_XOFF] = rd_hits_match;
        evt_clr[E_SPCH] = rd_hits_match | rx_char;
        evt_clr[E_FLOW] = rd_hits_flow;
    end

    irq_event_latch #(.WIDTH(NUM_EVT)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_set),
        .clr_i  (evt_clr),
        .hold_o (evt_q)
    );

    // mask each source with its enables, in priority order
    always_comb begin
        pend          = '0;
        pend[P_LINE]  = lsr_err   & ie_line;
        pend[P_TOUT]  = rx_tout   & ie_rx;
        pend[P_RXRDY] = rx_avail  & ie_rx;
        pend[P_TXRDY] = evt_q[E_TX] & ie_tx;
        pend[P_MODEM] = modem_chg & ie_modem;
        pend[P_MATCH] = (evt_q[E_XOFF] | evt_q[E_SPCH]) & ie_match & enh_en;
        pend[P_FLOW]  = evt_q[E_FLOW] & ie_flow & enh_en;
    end

    irq_prio_encoder #(.N(NUM_SRC)) u_enc (
        .pend_i (pend),
        .code_o (code)
    );

    irq_read_ctrl u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .isr_rd   (isr_rd),
        .fifo_en  (fifo_en),
        .code_i   (code),
        .isr_q    (isr_q),
        .irq      (irq),
        .rd_first (rd_first)
    );

endmodule

// File: rtl/irq_ident_chk.sv
// Module: irq_ident_chk
// Checker that watches the ports of uart_irq_ident on every cycle.
module irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       isr_rd,
    input logic       fifo_en,
    input logic       enh_en,
    input logic [7:0] isr_q,
    input logic       irq
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (isr_q == 8'h01 && !irq));

    // R4
    irq_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !isr_q[0]);

    // R2
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isr_q[5:0] inside {6'h06, 6'h0C, 6'h04, 6'h02, 6'h00, 6'h10, 6'h20, 6'h01});

    // R5
    fifo_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !isr_rd |=> isr_q[7:6] == {2{$past(fifo_en)}});

    // R7
    no_enh_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!isr_rd && !enh_en) |=> isr_q[5:4] == 2'b00);

    // R11
    read_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isr_rd |=> $stable(isr_q));

endmodule

bind uart_irq_ident irq_ident_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .isr_rd  (isr_rd),
    .fifo_en (fifo_en),
    .enh_en  (enh_en),
    .isr_q   (isr_q),
    .irq     (irq)
);

// File: tb/sim_uart_irq_ident.sv
// Bench: sweeps every source pattern and every enable pattern, predicting
// the status byte with an arithmetic model of the requirements.
module sim_uart_irq_ident;

    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lsr_err = 0, rx_tout = 0, rx_avail = 0, tx_ready = 0, modem_chg = 0;
    logic xoff_hit = 0, spchar_hit = 0, rx_char = 0, flow_deassert = 0;
    logic ie_line = 0, ie_rx = 0, ie_tx = 0, ie_modem = 0, ie_match = 0, ie_flow = 0;
    logic enh_en = 0, fifo_en = 0, isr_rd = 0;
    logic [7:0] isr_q;
    logic irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    uart_irq_ident u0 (
        .clk(clk), .rst_n(rst_n), .lsr_err(lsr_err), .rx_tout(rx_tout),
        .rx_avail(rx_avail), .tx_ready(tx_ready), .modem_chg(modem_chg),
        .xoff_hit(xoff_hit), .spchar_hit(spchar_hit), .rx_char(rx_char),
        .flow_deassert(flow_deassert), .ie_line(ie_line), .ie_rx(ie_rx),
        .ie_tx(ie_tx), .ie_modem(ie_modem), .ie_match(ie_match),
        .ie_flow(ie_flow), .enh_en(enh_en), .fifo_en(fifo_en),
        .isr_rd(isr_rd), .isr_q(isr_q), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%02h expected=%02h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // pattern bits: 0 line,1 tout,2 avail,3 tx,4 modem,5 match,6 flow
    // enables: 0 line,1 rx,2 tx,3 modem,4 match,5 flow
    function automatic logic [7:0] model(input logic [6:0] p, input logic [5:0] ie,
                                         input logic enh, input logic fe);
        logic [6:0] m;
        logic [5:0] c;
        m = p & {ie[5] & enh, ie[4] & enh, ie[3], ie[2], ie[1], ie[1], ie[0]};
        if (m[0]) c = 6'h06;
        else if (m[1]) c = 6'h0C;
        else if (m[2]) c = 6'h04;
        else if (m[3]) c = 6'h02;
        else if (m[4]) c = 6'h00;
        else if (m[5]) c = 6'h10;
        else if (m[6]) c = 6'h20;
        else c = 6'h01;
        return {{2{fe}}, c};
    endfunction

    task automatic set_cfg(input logic [5:0] ie, input logic enh, input logic fe);
        {ie_flow, ie_match, ie_modem, ie_tx, ie_rx, ie_line} = ie;
        enh_en = enh;
        fifo_en = fe;
    endtask

    task automatic do_read(output logic [7:0] v);
        isr_rd = 1'b1;
        tick(1);
        v = isr_q;
        isr_rd = 1'b0;
        tick(2);
    endtask

    // raise a pattern, check it, then drain latched events by reading
    task automatic run_pattern(input logic [6:0] p, input logic [5:0] ie,
                               input logic enh, input logic fe);
        logic [7:0] e, v;
        logic [6:0] rem;
        set_cfg(ie, enh, fe);
        lsr_err = p[0]; rx_tout = p[1]; rx_avail = p[2]; modem_chg = p[4];
        tx_ready = p[3]; xoff_hit = p[5]; flow_deassert = p[6];
        tick(1);
        tx_ready = 0; xoff_hit = 0; flow_deassert = 0;
        tick(2);
        e = model(p, ie, enh, fe);
        chk("R3 priority/R6 mask", isr_q, e);
        chk("R4 irq", {7'd0, irq}, {7'd0, ~e[0]});
        lsr_err = 0; rx_tout = 0; rx_avail = 0; modem_chg = 0;
        set_cfg(6'h3F, 1'b1, fe);
        tick(2);
        rem = p & 7'b1101000;
        for (int k = 0; k < 3 && rem != 0; k++) begin
            e = model(rem, 6'h3F, 1'b1, fe);
            do_read(v);
            chk("R9 R12 drain order", v, e);
            if (e[5:0] == 6'h02) rem[3] = 0;
            else if (e[5:0] == 6'h10) rem[5] = 0;
            else if (e[5:0] == 6'h20) rem[6] = 0;
        end
        chk("R9 idle after drain", isr_q, {{2{fe}}, 6'h01});
    endtask

    initial begin : watchdog
        #(CLK_P * 190000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        tick(4);
        chk("R1 reset isr", isr_q, 8'h01);
        chk("R1 reset irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        tick(1);
        chk("R1 idle after reset", isr_q, 8'h01);

        // R2 single sources, R3 all combinations, enhanced on
        for (int p = 0; p < 128; p++) run_pattern(p[6:0], 6'h3F, 1'b1, 1'b1);
        // R7 R8 enhanced off, FIFOs off (R5)
        for (int p = 0; p < 128; p++) run_pattern(p[6:0], 6'h3F, 1'b0, 1'b0);
        // R6 R7 R8 every enable combination with all sources present
        for (int ie = 0; ie < 64; ie++) run_pattern(7'h7F, ie[5:0], ie[0], ie[1]);

        // R5 fifo bits toggle with nothing pending
        set_cfg(6'h3F, 1'b1, 1'b1); tick(2);
        chk("R5 fifo on", isr_q, 8'hC1);
        fifo_en = 0; tick(2);
        chk("R5 fifo off", isr_q, 8'h01);

        // R10 special char cleared by next character
        spchar_hit = 1; tick(1); spchar_hit = 0; tick(2);
        chk("R10 special reported", isr_q, 8'h10);
        rx_char = 1; tick(1); rx_char = 0; tick(2);
        chk("R10 cleared by rx_char", isr_q, 8'h01);
        spchar_hit = 1; tick(1); spchar_hit = 0; tick(2);
        do_read(v);
        chk("R10 read returns match", v, 8'h10);
        chk("R10 cleared by read", isr_q, 8'h01);

        // R11 freeze over a long strobe; mid-strobe event survives
        tx_ready = 1; tick(1); tx_ready = 0; tick(2);
        chk("R11 tx before read", isr_q, 8'h02);
        isr_rd = 1; tick(1);
        chk("R11 frozen cycle 1", isr_q, 8'h02);
        lsr_err = 1; tx_ready = 1; tick(1); tx_ready = 0;
        chk("R11 frozen cycle 2", isr_q, 8'h02);
        tick(1);
        chk("R11 frozen cycle 3", isr_q, 8'h02);
        isr_rd = 0; tick(2);
        chk("R11 R12 line shown after read", isr_q, 8'h06);
        lsr_err = 0; tick(2);
        chk("R11 mid-strobe tx kept", isr_q, 8'h02);
        do_read(v);
        chk("R9 tx read", v, 8'h02);
        chk("R9 tx gone", isr_q, 8'h01);

        // R9 read reporting another code keeps tx latched
        tx_ready = 1; modem_chg = 0; rx_avail = 1; tick(1); tx_ready = 0; tick(2);
        do_read(v);
        chk("R9 read sees avail", v, 8'h04);
        rx_avail = 0; tick(2);
        chk("R9 tx survives foreign read", isr_q, 8'h02);
        do_read(v);
        chk("R9 tx drained", isr_q, 8'h01);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule